// File: doc/BRIEF.md
# Configuration Port Byte Transfer Controller

This peripheral sits on a simple processor register bus and moves bytes between a local dual-port buffer and an 8-bit internal configuration port. Software first fills the buffer with a stream of configuration bytes, or reserves space in it for read-back. It then programs a byte count and a starting buffer offset. Finally it writes the control register with a direction and a go bit, and polls a completion flag.

Once a transfer is running, the sequencer owns the second port of the buffer. It drives the port's active-low enable and write-select lines. It generates the port clock at half the block clock, so one byte moves per port clock when the port is ready. It stalls on the port's busy line without losing or repeating a byte. The buffer address wraps at the buffer depth.

A raw mode gives software direct bit-level control of the port through one 32-bit register, for low-rate use.

Top module: `cxf_ctrl`

## Requirements
- R1: After reset cp_ce_n and cp_wr_n are 1, cp_clk and cp_din are 0, and the size, offset, control and status registers all read 0.
- R2: In the write direction (control bit0 = 0), the block presents buffer bytes on cp_din in ascending address order, starting at the offset and wrapping at the buffer depth. The bytes sent are the size count. A port beat is a clock edge at which cp_clk is 1, cp_ce_n is 0 and cp_busy is 0.
- R3: In the read direction (control bit0 = 1), the byte on cp_dout at each beat is stored in the buffer, starting at the offset and wrapping at the depth. The bytes stored are the size count. Buffer entries outside that range keep their contents.
- R4: cp_wr_n holds the direction (0 for write, 1 for read) for at least one clock before cp_ce_n falls. It does not change while cp_ce_n is 0 and returns to 1 one clock after cp_ce_n rises.
- R5: An edge with cp_clk 1, cp_ce_n 0 and cp_busy 1 moves no byte. cp_din and the buffer position hold, and the same byte is retried in the next port clock.
- R6: While cp_ce_n is 0, cp_clk toggles every clock. With cp_busy low, the last of N bytes moves 2N+1 clocks after the go edge, and the done flag is set one clock later.
- R7: An accepted go clears the done flag (status bit0). Done is set once the size count of bytes has moved. A size of 0 sets done on the go edge and leaves the port idle.
- R8: While a transfer is active, a control register write is ignored. A go is ignored as well, so the running count, direction and data are unaffected.
- R9: With control bit1 set, the raw register drives the port: bits 7:0 drive cp_din, bit 8 drives cp_ce_n, bit 9 drives cp_wr_n and bit 10 drives cp_clk. Reads of the raw register return cp_dout in bits 23:16 and cp_busy in bit 24. A go written together with bit1 set is ignored.
- R10: Processor reads of the buffer while done is set leave the port idle and done set.
- R11: A bus access with bus_addr top bit 1 reaches the buffer byte at the low address bits. Otherwise bits 2:0 select a register: 0 size, 1 offset, 2 control (bit0 direction, bit1 raw, bit2 go; go reads as 0), 3 status and 4 raw. Read data appears on bus_rdata the clock after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Bus write when 1, read when 0 |
| bus_addr | input | ADDR_W+1 | Top bit selects buffer; low bits give byte or register index |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, one clock after the access |
| cp_din | output | 8 | Byte driven into the configuration port |
| cp_dout | input | 8 | Byte returned by the configuration port |
| cp_ce_n | output | 1 | Port enable, active low |
| cp_wr_n | output | 1 | Port write select, active low |
| cp_clk | output | 1 | Port clock |
| cp_busy | input | 1 | Port not ready when 1 |

## Verification
The bench builds the block with ADDR_W = 4 and SIZE_W = 6, which gives a 16-byte buffer. With so small a buffer, counts of 16 and 17 run off the end, so address wrap and read-back overwrite of the first entry are reached. Offsets 0, 9 and 15 put the wrap at different points in the stream, including the very first byte.

Each transfer shape is swept in both directions, once with the port always ready and once with busy raised on every third attempt. The expected beat cycle and stall count are computed arithmetically from that pattern.

// File: rtl/cxf_pkg.sv
package cxf_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ARM  = 2'd1,
    S_RUN  = 2'd2,
    S_FIN  = 2'd3
  } seq_state_t;

  localparam logic [2:0] IDX_SIZE = 3'd0;
  localparam logic [2:0] IDX_OFFS = 3'd1;
  localparam logic [2:0] IDX_CTRL = 3'd2;
  localparam logic [2:0] IDX_STAT = 3'd3;
  localparam logic [2:0] IDX_RAW  = 3'd4;

  localparam int CTRL_DIR = 0;
  localparam int CTRL_RAW = 1;
  localparam int CTRL_GO  = 2;

  localparam int RAW_CE  = 8;
  localparam int RAW_WR  = 9;
  localparam int RAW_CLK = 10;

  localparam logic [10:0] RAW_RESET = 11'b011_0000_0000;

  // Raw register read layout: drive bits low, port byte and busy above.
  function automatic logic [31:0] raw_word(input logic [10:0] drv,
                                           input logic [7:0] pdout,
                                           input logic pbusy);
    return {7'd0, pbusy, pdout, 5'd0, drv};
  endfunction

  function automatic logic [31:0] ctrl_word(input logic dir, input logic raw);
    return {30'd0, raw, dir};
  endfunction

endpackage

// File: rtl/cxf_dpram.sv
module cxf_dpram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wd,
  output logic [DW-1:0] a_rd,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wd,
  output logic [DW-1:0] b_rd
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_addr] <= a_wd;
      a_rd <= mem[a_addr];
    end
    if (b_we) mem[b_addr] <= b_wd;
    b_rd <= mem[b_addr];
  end
endmodule

// File: rtl/cxf_regs.sv
module cxf_regs
  import cxf_pkg::*;
#(
  parameter int AW = 11,
  parameter int SW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW:0]   bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          seq_active,
  input  logic          seq_done,
  input  logic [7:0]    port_dout,
  input  logic          port_busy,
  input  logic [7:0]    buf_rd,
  output logic          buf_en,
  output logic          buf_we,
  output logic [AW-1:0] buf_addr,
  output logic [7:0]    buf_wd,
  output logic [SW-1:0] size_q,
  output logic [AW-1:0] offs_q,
  output logic          raw_q,
  output logic [10:0]   raw_drv,
  output logic          go_wr,
  output logic          go,
  output logic          go_dir
);
  logic        buf_sel;
  logic [2:0]  idx;
  logic        wr_reg;
  logic        ctrl_ok;
  logic        dir_q;
  logic        buf_sel_q;
  logic [31:0] rd_next;
  logic [31:0] rd_q;

  assign buf_sel  = bus_addr[AW];
  assign idx      = bus_addr[2:0];
  assign wr_reg   = bus_en && bus_we && !buf_sel;
  assign ctrl_ok  = wr_reg && (idx == IDX_CTRL) && !seq_active;

  assign go_wr    = wr_reg && (idx == IDX_CTRL) && bus_wdata[CTRL_GO];
  assign go       = go_wr && !seq_active && !bus_wdata[CTRL_RAW];
  assign go_dir   = bus_wdata[CTRL_DIR];

  assign buf_en   = bus_en && buf_sel;
  assign buf_we   = bus_we;
  assign buf_addr = bus_addr[AW-1:0];
  assign buf_wd   = bus_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q  <= '0;
      offs_q  <= '0;
      dir_q   <= 1'b0;
      raw_q   <= 1'b0;
      raw_drv <= RAW_RESET;
    end else begin
      if (wr_reg && idx == IDX_SIZE) size_q  <= bus_wdata[SW-1:0];
      if (wr_reg && idx == IDX_OFFS) offs_q  <= bus_wdata[AW-1:0];
      if (wr_reg && idx == IDX_RAW)  raw_drv <= bus_wdata[10:0];
      if (ctrl_ok) begin
        dir_q <= bus_wdata[CTRL_DIR];
        raw_q <= bus_wdata[CTRL_RAW];
      end
    end
  end

  always_comb begin
    case (idx)
      IDX_SIZE: rd_next = 32'(size_q);
      IDX_OFFS: rd_next = 32'(offs_q);
      IDX_CTRL: rd_next = ctrl_word(dir_q, raw_q);
      IDX_STAT: rd_next = {31'd0, seq_done};
      IDX_RAW:  rd_next = raw_word(raw_drv, port_dout, port_busy);
      default:  rd_next = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q      <= '0;
      buf_sel_q <= 1'b0;
    end else if (bus_en && !bus_we) begin
      rd_q      <= rd_next;
      buf_sel_q <= buf_sel;
    end
  end

  assign bus_rdata = buf_sel_q ? {24'd0, buf_rd} : rd_q;
endmodule

// File: rtl/cxf_seq.sv
module cxf_seq
  import cxf_pkg::*;
#(
  parameter int AW = 11,
  parameter int SW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_dir,
  input  logic [SW-1:0] size,
  input  logic [AW-1:0] offs,
  input  logic          busy,
  input  logic [7:0]    pdout,
  input  logic [7:0]    ram_rd,
  output logic [AW-1:0] ram_addr,
  output logic          ram_we,
  output logic [7:0]    ram_wd,
  output logic          ce_n,
  output logic          wr_n,
  output logic          pclk,
  output logic [7:0]    pdin,
  output logic          active,
  output logic          done,
  output logic          beat,
  output logic          stall,
  output logic [SW-1:0] rem,
  output logic [AW-1:0] ptr
);
  seq_state_t state;
  logic dir_q;
  logic ce_n_q;
  logic wr_n_q;
  logic pclk_q;
  logic done_q;
  logic attempt;
  logic last;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return p + 1'b1;
  endfunction

  function automatic logic [SW-1:0] count_down(input logic [SW-1:0] c);
    return c - 1'b1;
  endfunction

  assign attempt  = (state == S_RUN) && pclk_q;
  assign beat     = attempt && !busy;
  assign stall    = attempt && busy;
  assign last     = beat && (rem == SW'(1));

  // Write direction prefetches the next byte on a beat; read direction stores at ptr.
  assign ram_addr = (beat && !dir_q) ? wrap_inc(ptr) : ptr;
  assign ram_we   = beat && dir_q;
  assign ram_wd   = pdout;

  assign ce_n   = ce_n_q;
  assign wr_n   = wr_n_q;
  assign pclk   = pclk_q;
  assign pdin   = (state == S_RUN && !dir_q) ? ram_rd : 8'd0;
  assign active = (state != S_IDLE);
  assign done   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ptr    <= '0;
      rem    <= '0;
      dir_q  <= 1'b0;
      ce_n_q <= 1'b1;
      wr_n_q <= 1'b1;
      pclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (go) begin
            if (size == '0) begin
              done_q <= 1'b1;
            end else begin
              done_q <= 1'b0;
              state  <= S_ARM;
              ptr    <= offs;
              rem    <= size;
              dir_q  <= go_dir;
              wr_n_q <= go_dir;
            end
          end
        end
        S_ARM: begin
          state  <= S_RUN;
          ce_n_q <= 1'b0;
          pclk_q <= 1'b0;
        end
        S_RUN: begin
          pclk_q <= ~pclk_q;
          if (beat) begin
            ptr <= wrap_inc(ptr);
            rem <= count_down(rem);
            if (last) begin
              state  <= S_FIN;
              ce_n_q <= 1'b1;
              pclk_q <= 1'b0;
            end
          end
        end
        S_FIN: begin
          wr_n_q <= 1'b1;
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cxf_ctrl.sv
module cxf_ctrl
  import cxf_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int SIZE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W:0]   bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [7:0]        cp_din,
  input  logic [7:0]        cp_dout,
  output logic              cp_ce_n,
  output logic              cp_wr_n,
  output logic              cp_clk,
  input  logic              cp_busy
);
  logic              buf_en, buf_we;
  logic [ADDR_W-1:0] buf_addr;
  logic [7:0]        buf_wd, buf_rd;
  logic [SIZE_W-1:0] size_q;
  logic [ADDR_W-1:0] offs_q;
  logic              raw_q;
  logic [10:0]       raw_drv;
  logic              go_wr, go, go_dir;

  logic [ADDR_W-1:0] seq_ram_addr;
  logic              seq_ram_we;
  logic [7:0]        seq_ram_wd, seq_ram_rd;
  logic              seq_ce_n, seq_wr_n, seq_pclk;
  logic [7:0]        seq_pdin;
  logic              seq_active, seq_done, seq_beat, seq_stall;
  logic [SIZE_W-1:0] seq_rem;
  logic [ADDR_W-1:0] seq_ptr;

  cxf_regs #(.AW(ADDR_W), .SW(SIZE_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .seq_active(seq_active), .seq_done(seq_done),
    .port_dout(cp_dout), .port_busy(cp_busy),
    .buf_rd(buf_rd), .buf_en(buf_en), .buf_we(buf_we),
    .buf_addr(buf_addr), .buf_wd(buf_wd),
    .size_q(size_q), .offs_q(offs_q), .raw_q(raw_q), .raw_drv(raw_drv),
    .go_wr(go_wr), .go(go), .go_dir(go_dir)
  );

  cxf_seq #(.AW(ADDR_W), .SW(SIZE_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .go(go), .go_dir(go_dir), .size(size_q), .offs(offs_q),
    .busy(cp_busy), .pdout(cp_dout),
    .ram_rd(seq_ram_rd), .ram_addr(seq_ram_addr), .ram_we(seq_ram_we),
    .ram_wd(seq_ram_wd),
    .ce_n(seq_ce_n), .wr_n(seq_wr_n), .pclk(seq_pclk), .pdin(seq_pdin),
    .active(seq_active), .done(seq_done),
    .beat(seq_beat), .stall(seq_stall), .rem(seq_rem), .ptr(seq_ptr)
  );

  cxf_dpram #(.AW(ADDR_W), .DW(8)) u_buf (
    .clk(clk),
    .a_en(buf_en), .a_we(buf_we), .a_addr(buf_addr), .a_wd(buf_wd), .a_rd(buf_rd),
    .b_we(seq_ram_we), .b_addr(seq_ram_addr), .b_wd(seq_ram_wd), .b_rd(seq_ram_rd)
  );

  assign cp_din  = raw_q ? raw_drv[7:0]     : seq_pdin;
  assign cp_ce_n = raw_q ? raw_drv[RAW_CE]  : seq_ce_n;
  assign cp_wr_n = raw_q ? raw_drv[RAW_WR]  : seq_wr_n;
  assign cp_clk  = raw_q ? raw_drv[RAW_CLK] : seq_pclk;
endmodule

// File: rtl/cxf_ctrl_chk.sv
module cxf_ctrl_chk #(
  parameter int AW = 11,
  parameter int SW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          seq_ce_n,
  input logic          seq_wr_n,
  input logic          seq_pclk,
  input logic [7:0]    seq_pdin,
  input logic          seq_active,
  input logic          seq_done,
  input logic          seq_beat,
  input logic          seq_stall,
  input logic [SW-1:0] seq_rem,
  input logic [AW-1:0] seq_ptr,
  input logic          go_wr,
  input logic          raw_q
);
  a_r4_wr_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_ce_n) |-> $stable(seq_wr_n));

  a_r4_wr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_ce_n && $past(!seq_ce_n)) |-> $stable(seq_wr_n));

  a_r5_hold_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
    seq_stall |=> ($stable(seq_pdin) && $stable(seq_rem) && $stable(seq_ptr)));

  a_r6_clock_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_ce_n && $past(!seq_ce_n)) |-> (seq_pclk != $past(seq_pclk)));

  a_r7_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> !seq_active);

  a_r7_release_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_beat && seq_rem == SW'(1)) |=> seq_ce_n);

  a_r8_go_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_active && go_wr && !seq_beat) |=> ($stable(seq_rem) && $stable(seq_ptr)));

  a_r9_raw_excludes_seq: assert property (@(posedge clk) disable iff (!rst_n)
    raw_q |-> !seq_active);
endmodule

bind cxf_ctrl cxf_ctrl_chk #(.AW(ADDR_W), .SW(SIZE_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .seq_ce_n(seq_ce_n), .seq_wr_n(seq_wr_n), .seq_pclk(seq_pclk),
  .seq_pdin(seq_pdin), .seq_active(seq_active), .seq_done(seq_done),
  .seq_beat(seq_beat), .seq_stall(seq_stall), .seq_rem(seq_rem),
  .seq_ptr(seq_ptr), .go_wr(go_wr), .raw_q(raw_q)
);

// File: tb/tb_cxf_ctrl.sv
module tb_cxf_ctrl;
  localparam int AW = 4;
  localparam int SW = 6;
  localparam int DEPTH = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_en = 1'b0, bus_we = 1'b0;
  logic [AW:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [7:0]    cp_din;
  logic [7:0]    cp_dout = 8'd0;
  logic          cp_ce_n, cp_wr_n, cp_clk;
  logic          cp_busy = 1'b0;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  // behavioural port model state
  logic model_on = 1'b0;
  logic busy_en = 1'b0;
  int   att = 0;
  int   nbeat = 0;
  int   last_cyc = 0;
  int   salt = 0;
  logic [7:0] cap [64];

  cxf_ctrl #(.ADDR_W(AW), .SIZE_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cp_din(cp_din), .cp_dout(cp_dout), .cp_ce_n(cp_ce_n),
    .cp_wr_n(cp_wr_n), .cp_clk(cp_clk), .cp_busy(cp_busy)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] rd_byte(input int k, input int s);
    return 8'((k * 53 + s + 7) & 255);
  endfunction

  function automatic logic [7:0] fill_byte(input int i, input int s);
    return 8'((i * 29 + s) & 255);
  endfunction

  // Drive busy/dout for the coming edge, then account for the beat on that edge.
  always @(negedge clk) begin
    if (model_on) begin
      cp_busy = busy_en && (att % 3 == 1);
      cp_dout = rd_byte(nbeat, salt);
      if (cp_clk && !cp_ce_n) begin
        if (!cp_busy) begin
          if (!cp_wr_n) cap[nbeat % 64] = cp_din;
          nbeat++;
          last_cyc = cyc + 1;
        end
        att++;
      end
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW:0] a, input logic [31:0] d, output int edge_no);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    edge_no = cyc + 1;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [AW:0] ra(input int idx);
    return {1'b0, AW'(idx)};
  endfunction
  function automatic logic [AW:0] ba(input int i);
    return {1'b1, AW'(i)};
  endfunction

  task automatic wait_done(output logic [31:0] st);
    st = 0;
    for (int k = 0; k < 300; k++) begin
      bus_rd(ra(3), st);
      if (st[0]) break;
    end
  endtask

  task automatic run_case(input logic dir, input int off, input int n, input logic be);
    int g, e, acc, a;
    logic [31:0] st, v;
    logic [7:0] expb [DEPTH];
    salt = salt + 11;
    for (int i = 0; i < DEPTH; i++) begin
      bus_wr(ba(i), 32'(fill_byte(i, salt)), e);
      expb[i] = fill_byte(i, salt);
    end
    bus_wr(ra(0), 32'(n), e);
    bus_wr(ra(1), 32'(off), e);
    att = 0; nbeat = 0; busy_en = be; last_cyc = 0;
    bus_wr(ra(2), {29'd0, 1'b1, 1'b0, dir}, g);
    if (n >= 2) begin
      bus_rd(ra(3), st);
      check(st[0] == 1'b0, "R7 done cleared by go", int'(st[0]), 0);
    end
    wait_done(st);
    check(st[0] == 1'b1, "R7 done after count", int'(st[0]), 1);
    check(nbeat == n, "R7 byte count", nbeat, n);
    acc = 0; a = 0;
    while (acc < n) begin
      if (!(be && (a % 3 == 1))) acc++;
      a++;
    end
    if (n > 0) begin
      if (be) check(last_cyc == g + 1 + 2 * a, "R5 stall retry timing", last_cyc - g, 1 + 2 * a);
      else    check(last_cyc == g + 1 + 2 * n, "R6 one byte per port clock", last_cyc - g, 1 + 2 * n);
    end
    if (!dir) begin
      for (int k = 0; k < n; k++)
        check(cap[k] == expb[(off + k) % DEPTH], "R2 written byte", int'(cap[k]),
              int'(expb[(off + k) % DEPTH]));
    end else begin
      for (int k = 0; k < n; k++) expb[(off + k) % DEPTH] = rd_byte(k, salt);
      for (int i = 0; i < DEPTH; i++) begin
        bus_rd(ba(i), v);
        check(v[7:0] == expb[i], "R3 stored byte", int'(v[7:0]), int'(expb[i]));
      end
      bus_rd(ra(3), st);
      check(st[0] == 1'b1 && cp_ce_n && !cp_clk, "R10 buffer reads leave port idle",
            int'({st[0], cp_ce_n, cp_clk}), 3'b110);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int e, g;
    int offs [3] = '{0, 9, 15};
    int sizes [5] = '{1, 2, 7, 16, 17};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cp_ce_n && cp_wr_n && !cp_clk && cp_din == 8'd0, "R1 port idle after reset",
          int'({cp_ce_n, cp_wr_n, cp_clk}), 3'b110);
    for (int r = 0; r < 4; r++) begin
      bus_rd(ra(r), v);
      check(v == 32'd0, "R1 register reset value", int'(v), 0);
    end
    // R11 register readback
    bus_wr(ra(0), 32'h2b, e);
    bus_rd(ra(0), v);
    check(v == 32'h2b, "R11 size readback", int'(v), 32'h2b);
    bus_wr(ra(1), 32'h7, e);
    bus_rd(ra(1), v);
    check(v == 32'h7, "R11 offset readback", int'(v), 7);
    bus_wr(ba(5), 32'hc3, e);
    bus_rd(ba(5), v);
    check(v == 32'hc3, "R11 buffer readback", int'(v), 32'hc3);

    // R7 zero size
    model_on = 1'b1; att = 0; nbeat = 0;
    bus_wr(ra(0), 32'd0, e);
    bus_wr(ra(2), 32'h4, g);
    check(cp_ce_n == 1'b1, "R7 zero size keeps port idle", int'(cp_ce_n), 1);
    bus_rd(ra(3), v);
    check(v[0] == 1'b1 && nbeat == 0, "R7 zero size sets done", int'(v[0]), 1);

    // R2 R3 R5 R6 sweep
    for (int d = 0; d < 2; d++)
      for (int o = 0; o < 3; o++)
        for (int s = 0; s < 5; s++)
          for (int b = 0; b < 2; b++)
            run_case(d[0], offs[o], sizes[s], b[0]);

    // R8 go while active is ignored
    salt = salt + 5;
    for (int i = 0; i < DEPTH; i++) bus_wr(ba(i), 32'(fill_byte(i, salt)), e);
    bus_wr(ra(0), 32'd10, e);
    bus_wr(ra(1), 32'd3, e);
    att = 0; nbeat = 0; busy_en = 1'b0;
    bus_wr(ra(2), 32'h4, g);
    bus_wr(ra(0), 32'd2, e);
    bus_wr(ra(2), 32'h5, e);
    check(cp_wr_n == 1'b0, "R8 direction unchanged", int'(cp_wr_n), 0);
    wait_done(v);
    check(nbeat == 10, "R8 count unchanged", nbeat, 10);
    check(cap[9] == fill_byte(12, salt), "R8 data unchanged", int'(cap[9]), int'(fill_byte(12, salt)));
    bus_rd(ra(2), v);
    check(v == 32'h0, "R8 control write ignored", int'(v), 0);

    // R9 raw mode
    model_on = 1'b0;
    @(negedge clk);
    cp_dout = 8'h96; cp_busy = 1'b1;
    bus_wr(ra(2), 32'h2, e);
    bus_wr(ra(4), 32'h0000_065a, e);
    @(negedge clk);
    check(cp_din == 8'h5a && !cp_ce_n && cp_wr_n && cp_clk, "R9 raw drive bits",
          int'({cp_clk, cp_wr_n, cp_ce_n, cp_din}), 32'h65a);
    bus_rd(ra(4), v);
    check(v == 32'h0196_065a, "R9 raw read format", int'(v), 32'h0196065a);
    bus_wr(ra(0), 32'd4, e);
    bus_wr(ra(2), 32'h6, e);
    repeat (4) @(negedge clk);
    check(cp_din == 8'h5a && !cp_ce_n && cp_clk, "R9 go ignored in raw mode",
          int'({cp_clk, cp_ce_n, cp_din}), 32'h25a);
    bus_rd(ra(3), v);
    check(v[0] == 1'b1, "R9 done untouched in raw mode", int'(v[0]), 1);
    bus_wr(ra(2), 32'h0, e);
    @(negedge clk);
    check(cp_ce_n && cp_wr_n && !cp_clk, "R9 raw off returns port idle",
          int'({cp_ce_n, cp_wr_n, cp_clk}), 3'b110);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule